// File: doc/BRIEF.md
# Arbitrated Message Fabric

A shared, synchronous interconnect that moves word-oriented messages between a small set of ports, one transfer at a time. Each port owns a transmit stream and a receive stream. A message is a single 32-bit header word followed by zero or more 32-bit payload words. The header carries the destination port ID, the originating port ID and the payload word count. Port IDs equal the port index, so IDs from 0 to N_PORTS-1 are valid.

The ports raise requests by presenting a header on their transmit stream. A round-robin arbiter spends one cycle choosing a winner. The winner then keeps the bus until it has sent its last word, at one word per cycle. Every accepted word is written into the receive FIFO of the destination port. The receiving logic pops that FIFO locally, so only writes ever cross the shared path. A message whose destination ID does not exist is consumed at full speed and thrown away, and a sticky error flag records the event. One port is designated as the processor-side port. Its interrupt output stays high for as long as its receive FIFO holds any word.

Back-pressure follows valid/ready rules on both streams. A transmit word moves on a rising edge where both tx_valid and tx_ready are high for that port. A sender must hold the word and keep valid high until it is taken. The fabric lowers tx_ready whenever the destination FIFO is full. A receive word is popped on an edge where rx_valid and rx_ready are both high. rx_data holds steady while rx_valid is high and the word has not been popped.

Top module: `msgbus_fabric`

## Requirements
- R1: A header word is laid out as bits [31:24] destination ID, bits [23:16] origin ID and bits [15:0] payload length in words. The header and then each payload word appear unchanged and in order on the destination port's receive stream.
- R2: At most one tx_ready bit is high in any cycle, and only the granted port's words are accepted.
- R3: On an idle fabric, a port that raises tx_valid has its header accepted on the second rising edge after that, because the first edge is the arbitration cycle. Each further word is accepted on the next edge when the destination is not full. After a message's last word, one arbitration cycle passes before any other word is accepted.
- R4: Requests are served in round-robin order. The next winner is the first requesting port after the most recently granted port, counting upward and wrapping to port 0. The grant is held from the header to the final payload word.
- R5: Each port has a 16-word receive FIFO. A buffered word stays on rx_data with rx_valid high until it is popped.
- R6: While the destination FIFO is full, the sender's tx_ready stays low. The transfer resumes once the receiver pops a word.
- R7: A message whose destination ID is N_PORTS or greater has all its words accepted at one per cycle. No receive stream shows any of them, and err_unknown_tgt rises and stays high until reset.
- R8: irq equals "the receive FIFO of port CPU_PORT is non-empty". It rises when a word lands there and falls when software has drained the FIFO.
- R9: After reset, every tx_ready and rx_valid bit is low, and irq and err_unknown_tgt are low.
- R10: A header with length 0 is a complete message of exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | N_PORTS | Per-port transmit word valid; a high bit is also that port's bus request |
| tx_data | input | 32*N_PORTS | Per-port transmit word; port p occupies bits [32p+31:32p] |
| tx_ready | output | N_PORTS | Per-port transmit accept; at most one bit is high |
| rx_valid | output | N_PORTS | Per-port receive FIFO non-empty |
| rx_data | output | 32*N_PORTS | Per-port head of the receive FIFO |
| rx_ready | input | N_PORTS | Per-port pop request |
| irq | output | 1 | Processor-side port has buffered words |
| err_unknown_tgt | output | 1 | Sticky flag: a message went to a nonexistent ID |

## Verification
The bench measures the exact edge on which each word is taken. This exposes a fabric that skips the arbitration cycle or inserts extra ones: the header would land one edge early or late. Three ports request in the same cycle, and the service order and the gap between messages are checked. A wrong rotation start would reorder the headers, and a grant dropped mid-message would interleave words. A 21-word message is aimed at a receiver that does not pop. A fabric without back-pressure would accept more than 16 words and lose data. An unknown destination, a zero-length header, a self-addressed message and a message that fills a FIFO exactly are also covered. A fabric that stalled on the unknown ID, forgot the error, or left the interrupt asserted after draining would each miss a check.

// File: rtl/msgbus_pkg.sv
package msgbus_pkg;
  localparam int WORD_W = 32;
  localparam int ID_W   = 8;
  localparam int LEN_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } bus_state_e;

  function automatic logic [ID_W-1:0] hdr_target(input logic [WORD_W-1:0] w);
    return w[31:24];
  endfunction

  function automatic logic [LEN_W-1:0] hdr_length(input logic [WORD_W-1:0] w);
    return w[15:0];
  endfunction
endpackage

// File: rtl/msgbus_rr_arb.sv
module msgbus_rr_arb #(
  parameter int N_PORTS = 3,
  parameter int IDX_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PORTS-1:0] req,
  input  logic             take,
  output logic             gnt_any,
  output logic [IDX_W-1:0] gnt_pick
);
  logic [IDX_W-1:0] last_q;

  // search starts one past the last winner and wraps
  always_comb begin
    gnt_any  = 1'b0;
    gnt_pick = '0;
    for (int off = 1; off <= N_PORTS; off++) begin
      int cand;
      cand = int'(last_q) + off;
      if (cand >= N_PORTS) cand = cand - N_PORTS;
      if (!gnt_any && req[cand]) begin
        gnt_any  = 1'b1;
        gnt_pick = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= IDX_W'(N_PORTS - 1);
    else if (take) last_q <= gnt_pick;
  end
endmodule

// File: rtl/msgbus_rx_fifo.sv
module msgbus_rx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign full     = (count == CW'(DEPTH));
  assign rd_valid = (count != '0);
  assign rd_data  = mem[rd_ptr];
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/msgbus_xfer_ctrl.sv
module msgbus_xfer_ctrl
  import msgbus_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int IDX_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] tx_valid,
  input  logic               gnt_any,
  input  logic [IDX_W-1:0]   gnt_pick,
  input  logic [ID_W-1:0]    hdr_tgt,
  input  logic [LEN_W-1:0]   hdr_len,
  input  logic [N_PORTS-1:0] tgt_full,
  output logic [N_PORTS-1:0] tx_ready,
  output logic               arb_take,
  output logic [IDX_W-1:0]   owner,
  output logic [N_PORTS-1:0] wr_en,
  output logic               err_flag
);
  bus_state_e        state_q;
  logic [IDX_W-1:0]  owner_q;
  logic [ID_W-1:0]   tgt_q;
  logic              drop_q;
  logic [LEN_W-1:0]  rem_q;
  logic              err_q;

  logic              in_hdr, hdr_unknown, cur_drop, space, beat_ok, fire;
  logic [ID_W-1:0]   cur_tgt;

  assign in_hdr      = (state_q == ST_HDR);
  assign hdr_unknown = (hdr_tgt >= ID_W'(N_PORTS));
  assign cur_tgt     = in_hdr ? hdr_tgt : tgt_q;
  assign cur_drop    = in_hdr ? hdr_unknown : drop_q;

  always_comb begin
    space = cur_drop;
    for (int i = 0; i < N_PORTS; i++) begin
      if (cur_tgt == ID_W'(i) && !tgt_full[i]) space = 1'b1;
    end
  end

  assign beat_ok  = (state_q != ST_IDLE) && space;
  assign fire     = beat_ok && tx_valid[owner_q];
  assign arb_take = (state_q == ST_IDLE) && gnt_any;
  assign owner    = owner_q;
  assign err_flag = err_q;

  always_comb begin
    tx_ready = '0;
    if (beat_ok) tx_ready[owner_q] = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < N_PORTS; i++) begin
      wr_en[i] = fire && !cur_drop && (cur_tgt == ID_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      tgt_q   <= '0;
      drop_q  <= 1'b0;
      rem_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (gnt_any) begin
            owner_q <= gnt_pick;
            state_q <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (fire) begin
            tgt_q   <= hdr_tgt;
            drop_q  <= hdr_unknown;
            rem_q   <= hdr_len;
            if (hdr_unknown) err_q <= 1'b1;
            state_q <= (hdr_len == '0) ? ST_IDLE : ST_PAY;
          end
        end
        ST_PAY: begin
          if (fire) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == LEN_W'(1)) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msgbus_fabric.sv
module msgbus_fabric
  import msgbus_pkg::*;
#(
  parameter int N_PORTS    = 3,
  parameter int FIFO_DEPTH = 16,
  parameter int CPU_PORT   = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        tx_valid,
  input  logic [N_PORTS*WORD_W-1:0] tx_data,
  output logic [N_PORTS-1:0]        tx_ready,
  output logic [N_PORTS-1:0]        rx_valid,
  output logic [N_PORTS*WORD_W-1:0] rx_data,
  input  logic [N_PORTS-1:0]        rx_ready,
  output logic                      irq,
  output logic                      err_unknown_tgt
);
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic               gnt_any, arb_take;
  logic [IDX_W-1:0]   gnt_pick, owner;
  logic [WORD_W-1:0]  sel_word;
  logic [N_PORTS-1:0] wr_en, tgt_full;

  msgbus_rr_arb #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (tx_valid),
    .take     (arb_take),
    .gnt_any  (gnt_any),
    .gnt_pick (gnt_pick)
  );

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (owner == IDX_W'(i)) sel_word = tx_data[i*WORD_W +: WORD_W];
    end
  end

  msgbus_xfer_ctrl #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .gnt_any  (gnt_any),
    .gnt_pick (gnt_pick),
    .hdr_tgt  (hdr_target(sel_word)),
    .hdr_len  (hdr_length(sel_word)),
    .tgt_full (tgt_full),
    .tx_ready (tx_ready),
    .arb_take (arb_take),
    .owner    (owner),
    .wr_en    (wr_en),
    .err_flag (err_unknown_tgt)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_rx
    msgbus_rx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en[p]),
      .wr_data  (sel_word),
      .full     (tgt_full[p]),
      .rd_valid (rx_valid[p]),
      .rd_data  (rx_data[p*WORD_W +: WORD_W]),
      .rd_ready (rx_ready[p])
    );
  end

  assign irq = rx_valid[CPU_PORT];
endmodule

// File: rtl/msgbus_fabric_chk.sv
module msgbus_fabric_chk #(
  parameter int N_PORTS  = 3,
  parameter int CPU_PORT = 0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_PORTS-1:0]      tx_valid,
  input logic [N_PORTS*32-1:0]   tx_data,
  input logic [N_PORTS-1:0]      tx_ready,
  input logic [N_PORTS-1:0]      rx_valid,
  input logic [N_PORTS-1:0]      rx_ready,
  input logic                    irq,
  input logic                    err_unknown_tgt
);
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic [N_PORTS-1:0] fire;
  logic [31:0]        fw;
  logic [IDX_W-1:0]   fidx, own_q;
  logic               in_msg_q, last_beat, hdr_bad;
  logic [15:0]        rem_q;

  assign fire = tx_valid & tx_ready;

  always_comb begin
    fw   = '0;
    fidx = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (fire[i]) begin
        fw   = tx_data[i*32 +: 32];
        fidx = IDX_W'(i);
      end
    end
  end

  assign last_beat = (|fire) && (in_msg_q ? (rem_q == 16'd1) : (fw[15:0] == 16'd0));
  assign hdr_bad   = (|fire) && !in_msg_q && (fw[31:24] >= 8'(N_PORTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_msg_q <= 1'b0;
      rem_q    <= '0;
      own_q    <= '0;
    end else if (|fire) begin
      if (!in_msg_q) begin
        in_msg_q <= (fw[15:0] != 16'd0);
        rem_q    <= fw[15:0];
        own_q    <= fidx;
      end else begin
        rem_q <= rem_q - 16'd1;
        if (rem_q == 16'd1) in_msg_q <= 1'b0;
      end
    end
  end

  assert_one_sender_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_ready));

  assert_arb_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (tx_ready == '0));

  assert_grant_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_msg_q && (|fire)) |-> fire[own_q]);

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rx_valid & ~rx_ready)) |=>
      ((rx_valid & $past(rx_valid & ~rx_ready)) == $past(rx_valid & ~rx_ready)));

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_bad |=> err_unknown_tgt);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_unknown_tgt |=> err_unknown_tgt);

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == rx_valid[CPU_PORT]);
endmodule

bind msgbus_fabric msgbus_fabric_chk #(.N_PORTS(N_PORTS), .CPU_PORT(CPU_PORT)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tx_valid        (tx_valid),
  .tx_data         (tx_data),
  .tx_ready        (tx_ready),
  .rx_valid        (rx_valid),
  .rx_ready        (rx_ready),
  .irq             (irq),
  .err_unknown_tgt (err_unknown_tgt)
);

// File: tb/msgbus_fabric_tb.sv
`timescale 1ns/1ps
module msgbus_fabric_tb;
  localparam int N = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    tx_valid, tx_ready, rx_valid, rx_ready;
  logic [N*32-1:0] tx_data, rx_data;
  logic            irq, err_unknown_tgt;

  logic            tb_valid [N];
  logic [31:0]     tb_data  [N];
  logic            tb_rready[N];

  int cyc = 0;
  int nchk = 0, nfail = 0;
  int nfire[N], first_fire[N], last_fire[N], start_cyc[N];
  logic [31:0] expq[$];
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tx_valid[i]          = tb_valid[i];
      tx_data[i*32 +: 32]  = tb_data[i];
      rx_ready[i]          = tb_rready[i];
    end
  end

  msgbus_fabric #(.N_PORTS(N), .FIFO_DEPTH(16), .CPU_PORT(0)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .irq(irq), .err_unknown_tgt(err_unknown_tgt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pay(input logic [31:0] seed, input int i);
    return seed + 32'(i) * 32'h0101_0001;
  endfunction

  task automatic push_exp(input int src, input int tgt, input int len, input logic [31:0] seed);
    expq.push_back({8'(tgt), 8'(src), 16'(len)});
    for (int i = 1; i <= len; i++) expq.push_back(pay(seed, i));
  endtask

  task automatic send(input int p, input int tgt, input int len, input logic [31:0] seed);
    int i = 0;
    bit first = 1'b1;
    nfire[p] = 0;
    while (i <= len) begin
      @(negedge clk);
      if (first) begin start_cyc[p] = cyc; first = 1'b0; end
      tb_valid[p] = 1'b1;
      tb_data[p]  = (i == 0) ? {8'(tgt), 8'(p), 16'(len)} : pay(seed, i);
      #1;
      if (tx_ready[p]) begin
        if (i == 0) first_fire[p] = cyc + 1;
        last_fire[p] = cyc + 1;
        nfire[p]++;
        i++;
      end
    end
    @(negedge clk);
    tb_valid[p] = 1'b0;
  endtask

  task automatic drain(input int p, input string req);
    int idle = 0;
    while (expq.size() > 0) begin
      @(negedge clk);
      tb_rready[p] = 1'b1;
      #1;
      if (rx_valid[p]) begin
        logic [31:0] w;
        w = expq.pop_front();
        chk(rx_data[p*32 +: 32] == w, req, rx_data[p*32 +: 32], w);
        idle = 0;
      end else begin
        idle++;
        if (idle > 200) begin
          chk(1'b0, req, 32'(expq.size()), 32'd0);
          expq.delete();
        end
      end
      @(posedge clk);
    end
    @(negedge clk);
    tb_rready[p] = 1'b0;
  endtask

  // src, tgt, len, seed
  localparam logic [63:0] VEC [6] = '{
    {8'd1, 8'd0, 16'd4,  32'hA000_0010},
    {8'd2, 8'd1, 16'd0,  32'h0000_0000},
    {8'd0, 8'd2, 16'd15, 32'h5A5A_0000},
    {8'd1, 8'd1, 16'd3,  32'hC0DE_0100},
    {8'd2, 8'd0, 16'd7,  32'h1234_5678},
    {8'd0, 8'd1, 16'd1,  32'hFFFF_FFF0}
  };

  initial begin
    for (int i = 0; i < N; i++) begin
      tb_valid[i] = 1'b0; tb_data[i] = '0; tb_rready[i] = 1'b0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(tx_ready == '0, "R9 tx_ready", 32'(tx_ready), 0);
    chk(rx_valid == '0, "R9 rx_valid", 32'(rx_valid), 0);
    chk(irq == 1'b0,    "R9 irq", 32'(irq), 0);
    chk(err_unknown_tgt == 1'b0, "R9 err", 32'(err_unknown_tgt), 0);

    // R3 timing on an idle fabric
    push_exp(1, 2, 2, 32'h0BAD_0000);
    send(1, 2, 2, 32'h0BAD_0000);
    chk(first_fire[1] == start_cyc[1] + 2, "R3 header edge", 32'(first_fire[1]), 32'(start_cyc[1] + 2));
    chk(last_fire[1] == start_cyc[1] + 4, "R3 last edge", 32'(last_fire[1]), 32'(start_cyc[1] + 4));
    drain(2, "R1 timing msg");

    // R4 round-robin: last grant was port 1, so order is 2, 0, 1
    push_exp(2, 2, 1, 32'h2000_0000);
    push_exp(0, 2, 1, 32'h0000_0000);
    push_exp(1, 2, 1, 32'h1000_0000);
    fork
      send(0, 2, 1, 32'h0000_0000);
      send(1, 2, 1, 32'h1000_0000);
      send(2, 2, 1, 32'h2000_0000);
    join
    chk(first_fire[2] == start_cyc[2] + 2, "R4 port2 first", 32'(first_fire[2]), 32'(start_cyc[2] + 2));
    chk(first_fire[0] == start_cyc[0] + 5, "R4 port0 second", 32'(first_fire[0]), 32'(start_cyc[0] + 5));
    chk(first_fire[1] == start_cyc[1] + 8, "R4 port1 third", 32'(first_fire[1]), 32'(start_cyc[1] + 8));
    drain(2, "R4 R1 contention order");

    // table of messages, each sent, held, then drained
    for (int v = 0; v < 6; v++) begin
      int s, t, l;
      s = int'(VEC[v][63:56]);
      t = int'(VEC[v][55:48]);
      l = int'(VEC[v][47:32]);
      push_exp(s, t, l, VEC[v][31:0]);
      send(s, t, l, VEC[v][31:0]);
      chk(nfire[s] == l + 1, "R1 R10 word count", 32'(nfire[s]), 32'(l + 1));
      repeat (3) @(negedge clk);
      #1;
      chk(rx_valid[t] && rx_data[t*32 +: 32] == expq[0], "R5 head held", rx_data[t*32 +: 32], expq[0]);
      drain(t, "R1 table msg");
    end

    // R6 back-pressure: 21 words into a 16-word FIFO
    push_exp(0, 1, 20, 32'h7700_0000);
    fork
      send(0, 1, 20, 32'h7700_0000);
      begin
        repeat (30) @(negedge clk);
        #1;
        chk(nfire[0] == 16, "R6 stalled count", 32'(nfire[0]), 32'd16);
        chk(tx_ready[0] == 1'b0, "R6 ready low", 32'(tx_ready[0]), 32'd0);
        drain(1, "R6 R1 resumed data");
      end
    join
    chk(nfire[0] == 21, "R6 total count", 32'(nfire[0]), 32'd21);

    // R7 unknown destination
    send(0, 7, 3, 32'hDEAD_0000);
    chk(nfire[0] == 4, "R7 words taken", 32'(nfire[0]), 32'd4);
    chk(last_fire[0] - first_fire[0] == 3, "R7 full rate", 32'(last_fire[0] - first_fire[0]), 32'd3);
    repeat (2) @(negedge clk);
    #1;
    chk(err_unknown_tgt == 1'b1, "R7 err set", 32'(err_unknown_tgt), 32'd1);
    chk(rx_valid == '0, "R7 nothing delivered", 32'(rx_valid), 32'd0);
    push_exp(1, 2, 0, 32'h0);
    send(1, 2, 0, 32'h0);
    drain(2, "R7 R10 later msg");
    chk(err_unknown_tgt == 1'b1, "R7 err sticky", 32'(err_unknown_tgt), 32'd1);

    // R8 interrupt with a zero-length message to the processor port
    chk(irq == 1'b0, "R8 irq idle", 32'(irq), 32'd0);
    push_exp(2, 0, 0, 32'h0);
    send(2, 0, 0, 32'h0);
    #1;
    chk(irq == 1'b1, "R8 irq raised", 32'(irq), 32'd1);
    drain(0, "R8 R10 header only");
    #1;
    chk(irq == 1'b0, "R8 irq cleared", 32'(irq), 32'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule